// File: doc/BRIEF.md
# Two-Lane Parallel Stage with Ordered Merge

This block speeds up a pipeline whose slow step needs several cycles per item. It keeps two identical copies of that slow step side by side. A dispatcher in front hands each new item to the copies in strict turn. A merge behind the copies takes the finished results back in the same turn, so items leave in the order they came in. Both edges use a valid/ready handshake.

Each copy holds an item for a fixed number of cycles, `WORK_CYCLES`, which defaults to 4. It then presents the item plus a constant, `ADD_K`. With two copies, a producer that offers one item every two cycles is never stalled. A single copy would leave that producer idle half of the time.

When the consumer is not ready, the finished result stays parked inside its copy. That copy counts as occupied until the result is taken. When the copy next in turn is occupied, the block lowers its input ready. The exception is a copy whose result is being taken in that same cycle: it can be refilled at once.

Top module: `pairStageWrap`

## Requirements
- R1: After reset, inReady is 1 and outValid is 0.
- R2: Every result equals the accepted input plus ADD_K, modulo 2^DATA_W (default ADD_K = 0x0123, DATA_W = 16).
- R3: An item accepted in cycle k by an empty block, with outReady held high, first shows outValid in cycle k+WORK_CYCLES (k+4 by default), and not earlier.
- R4: Results leave in exactly the order the items were accepted, and every accepted item leaves exactly once.
- R5: After reset the first item goes to copy 0, and later items alternate between the copies. With outReady held low, exactly two items are accepted.
- R6: inReady is 0 while the copy next in turn is occupied, unless that copy's result is taken in the same cycle. inReady is 1 whenever both copies are empty.
- R7: While outValid is 1 and outReady is 0, outValid stays 1 and outData stays unchanged in the next cycle.
- R8: A producer that offers an item every second cycle, with outReady always high, never sees inReady low when it offers.
- R9: A producer that offers an item in every cycle, with outReady always high, has exactly 20 items accepted in the first 40 cycles after reset (two accepted, then two refused, repeating).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Producer offers an item |
| inReady | output | 1 | Block accepts the offered item this cycle |
| inData | input | DATA_W | Offered item |
| outValid | output | 1 | A result is presented |
| outReady | input | 1 | Consumer takes the presented result |
| outData | output | DATA_W | Presented result |

## Verification
The dispatch turn, the merge turn and each copy's occupancy and countdown are all internal. None of them can be read directly, but each one goes wrong in a way the ports show within one item time.

- A merge turn out of step with the dispatch turn shows up as a result out of order, or as a stall that never ends, on the next transfer.
- A countdown loaded with the wrong value moves the first outValid away from cycle k+4.
- An occupancy flag that fails to clear holds inReady low, so the fixed-rate producer stalls within two offers.

The bench sweeps every pairing of producer gap (1 to 4 cycles) with four consumer ready patterns. It checks each result against the input plus the constant, in the order the items were accepted.

// File: rtl/pairStagePkg.sv
package pairStagePkg;

  localparam int LANES = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] laneLoad; // capture inData into this lane
    logic             outSel;   // lane whose result drives outData
  } laneStrobeT;

endpackage

// File: rtl/pairStageCtrl.sv
module pairStageCtrl
  import pairStagePkg::*;
#(
  parameter int WORK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output laneStrobeT strobe
);

  localparam int CNT_W = $clog2(WORK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WORK_CYCLES - 1);

  logic [LANES-1:0] laneBusy;
  logic [LANES-1:0] laneDone;
  logic [LANES-1:0] laneFree;
  logic [LANES-1:0] laneLoad;
  logic [CNT_W-1:0] laneCnt [LANES];
  logic             sendSel;
  logic             joinSel;
  logic             inFire;
  logic             outFire;

  assign outValid = laneDone[joinSel];
  assign outFire  = outValid && outReady;
  // a lane whose result leaves this cycle may be refilled at the same edge
  assign inReady  = !laneBusy[sendSel] || laneFree[sendSel];
  assign inFire   = inValid && inReady;

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      localparam logic LANE_ID = 1'(g);

      assign laneDone[g] = laneBusy[g] && (laneCnt[g] == '0);
      assign laneFree[g] = outFire && (joinSel == LANE_ID);
      assign laneLoad[g] = inFire && (sendSel == LANE_ID);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          laneBusy[g] <= 1'b0;
          laneCnt[g]  <= '0;
        end else if (laneLoad[g]) begin
          laneBusy[g] <= 1'b1;
          laneCnt[g]  <= CNT_LOAD;
        end else if (laneFree[g]) begin
          laneBusy[g] <= 1'b0;
        end else if (laneBusy[g] && (laneCnt[g] != '0)) begin
          laneCnt[g]  <= laneCnt[g] - 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sendSel <= 1'b0;
      joinSel <= 1'b0;
    end else begin
      if (inFire)  sendSel <= ~sendSel;
      if (outFire) joinSel <= ~joinSel;
    end
  end

  assign strobe.laneLoad = laneLoad;
  assign strobe.outSel   = joinSel;

  // ---------------- assertions ----------------
  logic [1:0] occCnt; // items inside, counted at the ports

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occCnt <= '0;
    else       occCnt <= occCnt + 2'(inFire) - 2'(outFire);
  end

  assert_occ_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(laneBusy) == 32'(occCnt));

  assert_valid_needs_item_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (occCnt != 2'd0));

  assert_empty_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (occCnt == 2'd0) |-> inReady);

  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((occCnt == 2'd2) && !outFire) |-> !inReady);

  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/pairStageData.sv
module pairStageData
  import pairStagePkg::*;
#(
  parameter int                DATA_W = 16,
  parameter logic [DATA_W-1:0] ADD_K  = 16'h0123
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  laneStrobeT        strobe,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] laneReg [LANES];

  generate
    for (genvar g = 0; g < LANES; g++) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   laneReg[g] <= '0;
        else if (strobe.laneLoad[g]) laneReg[g] <= inData + ADD_K;
      end
    end
  endgenerate

  assign outData = laneReg[strobe.outSel];

endmodule

// File: rtl/pairStageWrap.sv
module pairStageWrap
  import pairStagePkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                WORK_CYCLES = 4,
  parameter logic [DATA_W-1:0] ADD_K       = 16'h0123
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  laneStrobeT strobe;

  pairStageCtrl #(.WORK_CYCLES(WORK_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .outReady(outReady),
    .strobe  (strobe)
  );

  pairStageData #(.DATA_W(DATA_W), .ADD_K(ADD_K)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .inData (inData),
    .strobe (strobe),
    .outData(outData)
  );

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

endmodule

// File: tb/pairStageWrap_tb.sv
module pairStageWrap_tb;

  localparam int          DATA_W = 16;
  localparam logic [15:0] ADD_K  = 16'h0123;
  localparam time         CLK_P  = 4ns;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic              inReady;
  logic [DATA_W-1:0] inData;
  logic              outValid;
  logic              outReady;
  logic [DATA_W-1:0] outData;

  always #(CLK_P/2) clk = ~clk;

  pairStageWrap #(.DATA_W(DATA_W), .WORK_CYCLES(4), .ADD_K(ADD_K)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  int          total = 0;
  int          bad   = 0;
  int          cyc   = 0;
  int          accTotal = 0;
  int          outTotal = 0;
  int          stallTotal = 0;
  bit          accFlag;
  bit          prevStall = 0;
  logic [15:0] prevData;
  logic [15:0] expMem [1024];
  logic [9:0]  head = '0;
  logic [9:0]  tail = '0;
  logic [15:0] dataCnt = 16'hFF00;
  logic [7:0]  lfsr = 8'hA5;

  task automatic check(input bit cond, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // one clock cycle: sample at negedge, drive after posedge
  task automatic step();
    @(negedge clk);
    accFlag = 0;
    if (prevStall)
      check(outValid && (outData == prevData), "R7",
            {15'd0, outValid, outData}, {16'd1, prevData});
    prevStall = outValid && !outReady;
    prevData  = outData;
    if (outValid && outReady) begin
      if (head == tail) check(1'b0, "R4 unexpected output", 32'(outData), 32'hFFFF_FFFF);
      else begin
        check(outData == expMem[head], "R2/R4", 32'(outData), 32'(expMem[head]));
        head++;
      end
      outTotal++;
    end
    if (inValid && inReady) begin
      expMem[tail] = inData + ADD_K;
      tail++;
      accTotal++;
      accFlag = 1;
    end
    if (inValid && !inReady) stallTotal++;
    @(posedge clk);
    #1;
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0; inData = '0;
    prevStall = 0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    head = tail;
  endtask

  task automatic runStream(input int n, input int gap, input int mode);
    int sent = 0;
    int idle = 0;
    int outStart = outTotal;
    int stallStart = stallTotal;
    int guard = 0;
    inValid = 0;
    while (((sent < n) || (head != tail)) && (guard < 2000)) begin
      if (!inValid && (sent < n) && (idle == 0)) begin
        inValid = 1;
        inData  = dataCnt;
        dataCnt = dataCnt + 16'h0137;
      end
      case (mode)
        0: outReady = 1'b1;
        1: outReady = cyc[0];
        2: outReady = lfsr[0];
        default: outReady = ((cyc % 16) < 10);
      endcase
      step();
      guard++;
      if (accFlag) begin
        sent++;
        inValid = 0;
        idle = gap - 1;
      end else if (!inValid && (idle > 0)) begin
        idle--;
      end
    end
    check((outTotal - outStart) == n, "R4 item count", 32'(outTotal - outStart), 32'(n));
    if ((gap == 2) && (mode == 0))
      check((stallTotal - stallStart) == 0, "R8 producer stalls",
            32'(stallTotal - stallStart), 32'd0);
    inValid = 0;
    outReady = 0;
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int accWin;
    doReset();

    // R1: reset state
    check(inReady == 1'b1, "R1 inReady", 32'(inReady), 32'd1);
    check(outValid == 1'b0, "R1 outValid", 32'(outValid), 32'd0);

    // R3: latency from an empty block
    inValid = 1; inData = 16'h1000; outReady = 1;
    step();
    inValid = 0;
    for (int i = 1; i < 4; i++) begin
      check(outValid == 1'b0, "R3 early outValid", 32'(outValid), 32'd0);
      step();
    end
    check(outValid == 1'b1, "R3 outValid at k+4", 32'(outValid), 32'd1);
    check(outData == 16'h1123, "R2 first result", 32'(outData), 32'h1123);
    step();

    // R5/R6/R7: consumer stalled, continuous offers
    doReset();
    outReady = 0;
    accWin = accTotal;
    for (int i = 0; i < 10; i++) begin
      inValid = 1;
      inData  = 16'hFFFE + 16'(i);
      step();
    end
    check((accTotal - accWin) == 2, "R5 accepted while stalled",
          32'(accTotal - accWin), 32'd2);
    check(inReady == 1'b0, "R6 inReady low when lane busy", 32'(inReady), 32'd0);
    inValid = 0;
    outReady = 1;
    repeat (4) step();
    check(head == tail, "R4 drained in order", 32'(tail - head), 32'd0);

    // R9: saturated producer
    doReset();
    outReady = 1;
    accWin = accTotal;
    inValid = 1;
    inData = dataCnt;
    for (int i = 0; i < 40; i++) begin
      step();
      if (accFlag) begin
        dataCnt = dataCnt + 16'h0011;
        inData  = dataCnt;
      end
    end
    check((accTotal - accWin) == 20, "R9 accepts in 40 cycles",
          32'(accTotal - accWin), 32'd20);
    inValid = 0;
    repeat (8) step();
    check(head == tail, "R4 saturated drain", 32'(tail - head), 32'd0);

    // sweep: producer gap x consumer ready pattern (R2 R4 R7 R8)
    for (int gap = 1; gap <= 4; gap++) begin
      for (int mode = 0; mode < 4; mode++) begin
        doReset();
        runStream(24, gap, mode);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule